// File: doc/BRIEF.md
# Configurable Logic Element With Carry

This block is a single cell of a lookup-table based programmable fabric. A truth table, held in configuration bits, is read either as one function of all data inputs or, in arithmetic mode, as two smaller functions: one gives a sum bit and the other gives a carry-out. Both halves are indexed by the carry-in and the low data inputs. A single storage bit follows the table. It can be set up to behave as a D, T, JK or SR flip-flop. It has an asynchronous clear, a synchronous clear, a synchronous load and a clock enable.

The flip-flop can take its source from a dedicated chain input in place of the table, so several cells can form a shift path. Its state always leaves on a chain output for the next cell. The cell output is either the table result or the stored bit. Cells are tiled by joining each carry-out to the next carry-in, which gives adders, counters and comparators that need no routing between cells.

Top module: `carry_logic_cell`

## Requirements
- R1: With `cfgArith`=0 and `cfgOutReg`=0, `cellOut` equals `cfgTable[dataIn]` (bit index is the data input value), combinationally.
- R2: With `cfgArith`=1, the index is idx = {carryIn, dataIn[1], dataIn[0]}. The sum is `cfgTable[idx]` (bits 7:0) and `carryOut` is `cfgTable[8+idx]` (bits 15:8). `dataIn[3:2]` have no effect. The table value 16'hE896 makes the cell a full adder.
- R3: With `cfgArith`=0, `carryOut` is 0 whatever the other inputs are.
- R4: Register kind 0 (D): on an enabled edge the stored bit takes the source bit.
- R5: Register kind 1 (T): on an enabled edge the stored bit inverts when the source bit is 1 and holds otherwise.
- R6: Register kind 2 (JK): J is the source bit and K is `auxCtl`. On an enabled edge, 00 holds, 10 sets, 01 clears and 11 inverts.
- R7: Register kind 3 (SR): S is the source bit and R is `auxCtl`. On an enabled edge R clears the bit, and it wins when S is also 1. S alone sets the bit, and neither holds it.
- R8: `clrAsync` high forces the stored bit to 0 at once, without a clock edge, and holds it at 0 over any edge regardless of all other controls.
- R9: `syncClr` high clears the stored bit at the next edge. It overrides `syncLoad` and `clkEn`.
- R10: `syncLoad` high (and `syncClr` low) stores `loadData` at the next edge even when `clkEn` is low. With all three low, the bit holds.
- R11: With `cfgChainIn`=1 the source bit is `chainIn` and the table result does not reach the flip-flop.
- R12: `chainOut` always shows the stored bit. `cellOut` shows the stored bit when `cfgOutReg`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clrAsync | input | 1 | Asynchronous clear of the stored bit, active high |
| cfgTable | input | 2**K | Truth table configuration bits |
| cfgArith | input | 1 | 1 selects the split sum/carry mode |
| cfgRegKind | input | 2 | Flip-flop behaviour: 0 D, 1 T, 2 JK, 3 SR |
| cfgChainIn | input | 1 | 1 feeds the flip-flop from chainIn |
| cfgOutReg | input | 1 | 1 drives cellOut from the stored bit |
| dataIn | input | K | Data inputs indexing the table |
| carryIn | input | 1 | Carry from the previous cell |
| chainIn | input | 1 | Register chain input from the previous cell |
| auxCtl | input | 1 | Second flip-flop control (K in JK, R in SR) |
| clkEn | input | 1 | Clock enable for the flip-flop function |
| syncClr | input | 1 | Synchronous clear |
| syncLoad | input | 1 | Synchronous load of loadData |
| loadData | input | 1 | Value stored by a synchronous load |
| cellOut | output | 1 | Table result or stored bit |
| carryOut | output | 1 | Carry to the next cell |
| chainOut | output | 1 | Stored bit, to the next cell's chain input |

## Verification
The bench builds the cell with K=4, which gives a 16-entry table and two 8-entry halves. At that size every normal index under several tables and every one of the 32 arithmetic input combinations can be swept exhaustively. The same K=4 setting makes a 64-pattern control sweep per flip-flop kind cheap enough to run. Eight such cells chained through their carries as a counter take all 256 states and the wrap, so the full carry ripple and the all-ones carry-out are both exercised.

// File: rtl/carry_cell_pkg.sv
package carry_cell_pkg;

  typedef enum logic [1:0] {
    KIND_D  = 2'd0,
    KIND_T  = 2'd1,
    KIND_JK = 2'd2,
    KIND_SR = 2'd3
  } regKind_e;

  // Strobes from the control to the storage bit; at most one is meant to act
  typedef struct packed {
    logic clear;
    logic load;
    logic set;
    logic toggle;
  } regStrobe_t;

endpackage

// File: rtl/carry_cell_lut.sv
module carry_cell_lut #(
  parameter int K = 4
) (
  input  logic [(1<<K)-1:0] cfgTable,
  input  logic              cfgArith,
  input  logic [K-1:0]      dataIn,
  input  logic              carryIn,
  output logic              lutResult,
  output logic              carryOut
);
  localparam int TABLE_BITS = 1 << K;
  localparam int HALF_W     = K - 1;

  logic [HALF_W-1:0] halfIdx;
  logic [K-1:0]      sumIdx;
  logic [K-1:0]      carryIdx;

  // carry-in sits on the top index bit of each half
  assign halfIdx  = {carryIn, dataIn[K-3:0]};
  assign sumIdx   = {1'b0, halfIdx};
  assign carryIdx = {1'b1, halfIdx};

  always_comb begin
    if (cfgArith) begin
      lutResult = cfgTable[sumIdx];
      carryOut  = cfgTable[carryIdx];
    end else begin
      lutResult = cfgTable[dataIn];
      carryOut  = 1'b0;
    end
  end

  initial begin
    assert (TABLE_BITS >= 8) else $error("K must be at least 3");
  end

endmodule

// File: rtl/carry_cell_control.sv
module carry_cell_control
  import carry_cell_pkg::*;
(
  input  regKind_e   regKind,
  input  logic       cfgChainIn,
  input  logic       chainIn,
  input  logic       lutResult,
  input  logic       auxCtl,
  input  logic       clkEn,
  input  logic       syncClr,
  input  logic       syncLoad,
  output regStrobe_t strobe
);
  logic srcBit;

  assign srcBit = cfgChainIn ? chainIn : lutResult;

  // priority: synchronous clear, then load, then the enabled flip-flop function
  always_comb begin
    strobe = '0;
    if (syncClr) begin
      strobe.clear = 1'b1;
    end else if (syncLoad) begin
      strobe.load = 1'b1;
    end else if (clkEn) begin
      unique case (regKind)
        KIND_D: begin
          strobe.set   = srcBit;
          strobe.clear = ~srcBit;
        end
        KIND_T: strobe.toggle = srcBit;
        KIND_JK: begin
          strobe.toggle = srcBit & auxCtl;
          strobe.set    = srcBit & ~auxCtl;
          strobe.clear  = ~srcBit & auxCtl;
        end
        KIND_SR: begin
          strobe.clear = auxCtl;
          strobe.set   = srcBit & ~auxCtl;
        end
        default: strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/carry_cell_datapath.sv
module carry_cell_datapath
  import carry_cell_pkg::*;
(
  input  logic       clk,
  input  logic       clrAsync,
  input  regStrobe_t strobe,
  input  logic       loadData,
  input  logic       lutResult,
  input  logic       cfgOutReg,
  output logic       regQ,
  output logic       cellOut
);
  logic nextQ;

  always_comb begin
    if (strobe.clear)       nextQ = 1'b0;
    else if (strobe.load)   nextQ = loadData;
    else if (strobe.set)    nextQ = 1'b1;
    else if (strobe.toggle) nextQ = ~regQ;
    else                    nextQ = regQ;
  end

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync) regQ <= 1'b0;
    else          regQ <= nextQ;
  end

  assign cellOut = cfgOutReg ? regQ : lutResult;

  // R8: the asynchronous clear keeps the bit at zero across any edge
  assert_async_clear_R8: assert property (@(posedge clk) clrAsync |-> regQ == 1'b0);

endmodule

// File: rtl/carry_logic_cell.sv
module carry_logic_cell
  import carry_cell_pkg::*;
#(
  parameter int K = 4
) (
  input  logic              clk,
  input  logic              clrAsync,
  input  logic [(1<<K)-1:0] cfgTable,
  input  logic              cfgArith,
  input  logic [1:0]        cfgRegKind,
  input  logic              cfgChainIn,
  input  logic              cfgOutReg,
  input  logic [K-1:0]      dataIn,
  input  logic              carryIn,
  input  logic              chainIn,
  input  logic              auxCtl,
  input  logic              clkEn,
  input  logic              syncClr,
  input  logic              syncLoad,
  input  logic              loadData,
  output logic              cellOut,
  output logic              carryOut,
  output logic              chainOut
);
  logic       lutResult;
  logic       regQ;
  regStrobe_t strobe;
  regKind_e   regKind;

  assign regKind = regKind_e'(cfgRegKind);

  carry_cell_lut #(.K(K)) u_lut (
    .cfgTable (cfgTable),
    .cfgArith (cfgArith),
    .dataIn   (dataIn),
    .carryIn  (carryIn),
    .lutResult(lutResult),
    .carryOut (carryOut)
  );

  carry_cell_control u_ctrl (
    .regKind   (regKind),
    .cfgChainIn(cfgChainIn),
    .chainIn   (chainIn),
    .lutResult (lutResult),
    .auxCtl    (auxCtl),
    .clkEn     (clkEn),
    .syncClr   (syncClr),
    .syncLoad  (syncLoad),
    .strobe    (strobe)
  );

  carry_cell_datapath u_dp (
    .clk      (clk),
    .clrAsync (clrAsync),
    .strobe   (strobe),
    .loadData (loadData),
    .lutResult(lutResult),
    .cfgOutReg(cfgOutReg),
    .regQ     (regQ),
    .cellOut  (cellOut)
  );

  assign chainOut = regQ;

  // R9: synchronous clear wins over load and enable
  assert_sync_clear_R9: assert property (@(posedge clk) disable iff (clrAsync)
    syncClr |=> chainOut == 1'b0);

  // R10: load stores loadData regardless of the clock enable
  assert_sync_load_R10: assert property (@(posedge clk) disable iff (clrAsync)
    (syncLoad && !syncClr) |=> chainOut == $past(loadData));

  // R10: nothing enabled, nothing changes
  assert_hold_R10: assert property (@(posedge clk) disable iff (clrAsync)
    (!syncLoad && !syncClr && !clkEn) |=> $stable(chainOut));

  // R4: D behaviour captures the table result
  assert_d_capture_R4: assert property (@(posedge clk) disable iff (clrAsync)
    (clkEn && !syncClr && !syncLoad && cfgRegKind == 2'd0 && !cfgChainIn)
      |=> chainOut == $past(lutResult));

  // R11: chain input bypasses the table
  assert_chain_bypass_R11: assert property (@(posedge clk) disable iff (clrAsync)
    (clkEn && !syncClr && !syncLoad && cfgRegKind == 2'd0 && cfgChainIn)
      |=> chainOut == $past(chainIn));

  // R7: reset side of SR dominates
  assert_sr_reset_R7: assert property (@(posedge clk) disable iff (clrAsync)
    (clkEn && !syncClr && !syncLoad && cfgRegKind == 2'd3 && auxCtl)
      |=> chainOut == 1'b0);

  // R2: with the adder table the carry is the majority of its three inputs
  assert_adder_carry_R2: assert property (@(posedge clk) disable iff (clrAsync)
    (cfgArith && cfgTable == 16'hE896)
      |-> carryOut == ((dataIn[0] & dataIn[1]) | (carryIn & (dataIn[0] ^ dataIn[1]))));

endmodule

// File: tb/test_carry_logic_cell.sv
module test_carry_logic_cell;

  logic        clk;
  logic        clrAsync;
  logic [15:0] cfgTable;
  logic        cfgArith;
  logic [1:0]  cfgRegKind;
  logic        cfgChainIn;
  logic        cfgOutReg;
  logic [3:0]  dataIn;
  logic        carryIn;
  logic        chainIn;
  logic        auxCtl;
  logic        clkEn;
  logic        syncClr;
  logic        syncLoad;
  logic        loadData;
  logic        cellOut;
  logic        carryOut;
  logic        chainOut;

  int  testCount = 0;
  int  failCount = 0;
  bit  benchDone = 0;
  logic modelQ;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  carry_logic_cell #(.K(4)) i_carry_logic_cell (
    .clk(clk), .clrAsync(clrAsync), .cfgTable(cfgTable), .cfgArith(cfgArith),
    .cfgRegKind(cfgRegKind), .cfgChainIn(cfgChainIn), .cfgOutReg(cfgOutReg),
    .dataIn(dataIn), .carryIn(carryIn), .chainIn(chainIn), .auxCtl(auxCtl),
    .clkEn(clkEn), .syncClr(syncClr), .syncLoad(syncLoad), .loadData(loadData),
    .cellOut(cellOut), .carryOut(carryOut), .chainOut(chainOut)
  );

  // eight-cell ripple counter in arithmetic mode
  logic       cntClr;
  logic [7:0] cntQ;
  logic [7:0] cntCell;
  logic [8:0] cntCin;
  assign cntCin[0] = 1'b1;

  for (genvar g = 0; g < 8; g++) begin : g_cnt
    carry_logic_cell #(.K(4)) u_cell (
      .clk(clk), .clrAsync(cntClr), .cfgTable(16'hE896), .cfgArith(1'b1),
      .cfgRegKind(2'd0), .cfgChainIn(1'b0), .cfgOutReg(1'b1),
      .dataIn({3'b000, cntQ[g]}), .carryIn(cntCin[g]), .chainIn(1'b0),
      .auxCtl(1'b0), .clkEn(1'b1), .syncClr(1'b0), .syncLoad(1'b0),
      .loadData(1'b0), .cellOut(cntCell[g]), .carryOut(cntCin[g+1]),
      .chainOut(cntQ[g])
    );
  end

  task automatic check(input string req, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!benchDone) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [15:0] tables [4];
    clrAsync = 0; cntClr = 0; cfgTable = '0; cfgArith = 0; cfgRegKind = 0;
    cfgChainIn = 0; cfgOutReg = 1; dataIn = 0; carryIn = 0; chainIn = 0;
    auxCtl = 0; clkEn = 0; syncClr = 0; syncLoad = 0; loadData = 0;
    #1 clrAsync = 1; cntClr = 1;
    @(negedge clk);
    check("R8 reset chainOut", chainOut, 0);
    check("R12 reset cellOut", cellOut, 0);
    clrAsync = 0;

    // R1 and R3: normal mode table reads
    tables[0] = 16'h6996; tables[1] = 16'hF00D; tables[2] = 16'h8001; tables[3] = 16'h1234;
    cfgOutReg = 0;
    for (int t = 0; t < 4; t++) begin
      cfgTable = tables[t];
      for (int i = 0; i < 16; i++) begin
        dataIn = 4'(i); carryIn = i[0];
        #1;
        check("R1 normal read", cellOut, tables[t][i]);
        check("R3 no carry in normal mode", carryOut, 0);
      end
    end

    // R2: arithmetic split, adder table and an arbitrary table
    cfgArith = 1;
    for (int t = 0; t < 2; t++) begin
      cfgTable = (t == 0) ? 16'hE896 : 16'h3C5A;
      for (int v = 0; v < 32; v++) begin
        logic a, b, c;
        int   idx;
        a = v[0]; b = v[1]; c = v[4];
        dataIn = v[3:0]; carryIn = c;
        idx = {c, b, a};
        #1;
        if (t == 0) begin
          check("R2 adder sum", cellOut, a ^ b ^ c);
          check("R2 adder carry", carryOut, (a & b) | (c & (a ^ b)));
        end else begin
          check("R2 split sum", cellOut, cfgTable[idx]);
          check("R2 split carry", carryOut, cfgTable[8 + idx]);
        end
      end
    end

    // R4-R7, R9, R10, R12: control sweep per kind, lut result = dataIn[0]
    @(negedge clk);
    cfgArith = 0; cfgOutReg = 1; cfgTable = 16'hAAAA; dataIn = 0;
    syncClr = 1;
    tick();
    modelQ = 0;
    syncClr = 0;
    check("R9 initial clear", chainOut, 0);
    for (int kind = 0; kind < 4; kind++) begin
      cfgRegKind = 2'(kind);
      for (int n = 0; n < 128; n++) begin
        int v;
        logic s, r, en, sc, sl, ld;
        string tag;
        v = (n * 37 + (n >> 6) * 11) & 63;
        s = v[0]; r = v[1]; en = v[2]; sc = v[3]; sl = v[4]; ld = v[5];
        dataIn = {3'b000, s}; auxCtl = r; clkEn = en;
        syncClr = sc; syncLoad = sl; loadData = ld;
        tick();
        if (sc) begin
          modelQ = 0; tag = "R9 sync clear";
        end else if (sl) begin
          modelQ = ld; tag = "R10 sync load";
        end else if (!en) begin
          tag = "R10 hold";
        end else begin
          case (kind)
            0: begin modelQ = s; tag = "R4 D kind"; end
            1: begin modelQ = modelQ ^ s; tag = "R5 T kind"; end
            2: begin
              if (s && r) modelQ = ~modelQ;
              else if (s) modelQ = 1;
              else if (r) modelQ = 0;
              tag = "R6 JK kind";
            end
            default: begin
              if (r) modelQ = 0;
              else if (s) modelQ = 1;
              tag = "R7 SR kind";
            end
          endcase
        end
        check(tag, chainOut, modelQ);
        check("R12 cellOut shows register", cellOut, modelQ);
      end
    end

    // R11: chain input bypass, table would give the opposite value
    syncClr = 0; syncLoad = 0; clkEn = 1; cfgRegKind = 0; cfgChainIn = 1;
    for (int n = 0; n < 8; n++) begin
      logic ci;
      ci = (8'b1011_0010 >> n) & 1'b1;
      chainIn = ci;
      cfgTable = ci ? 16'h0000 : 16'hFFFF;
      dataIn = 4'(n);
      tick();
      check("R11 chain bypass", chainOut, ci);
    end
    cfgChainIn = 0;

    // R8: asynchronous clear between edges and over an edge
    syncLoad = 1; loadData = 1;
    tick();
    check("R10 load before clear", chainOut, 1);
    #3 clrAsync = 1;
    #2;
    check("R8 clear without edge", chainOut, 0);
    check("R8 clear reaches cellOut", cellOut, 0);
    tick();
    check("R8 clear over load edge", chainOut, 0);
    clrAsync = 0; syncLoad = 0; clkEn = 0;
    tick();
    check("R10 hold after clear", chainOut, 0);

    // R2/R4/R12: eight-cell counter
    cntClr = 0;
    for (int k = 1; k <= 300; k++) begin
      tick();
      check("R2 counter value", cntQ, k & 255);
      check("R2 counter carry out", cntCin[8], ((k & 255) == 255) ? 1 : 0);
      check("R12 counter cellOut", cntCell, k & 255);
    end

    benchDone = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule